// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block raises an interrupt request whenever the sampled level of a parallel port differs from a stored reference byte. It drives an active-low, open-drain request line. The only output is a pull-low enable. When the enable is 1, the pad pulls the shared line low. When it is 0, the pad releases the line, and an external resistor brings it high.

The reference byte holds the port state that the host last observed. It is refreshed by two events from the serial front end:

- a one-cycle read-sample pulse, at the moment the port is captured for a read;
- the trailing end of a write-commit pulse.

Because the request is a level comparison and not a latched edge, it withdraws by itself when the pins go back to the reference. Any later departure raises it again.

The port byte is expected to arrive already synchronized to the block clock. The same byte feeds both the comparison and the reference load.

Top module: `port_change_irq`

## Requirements
- R1: While `rst_n` is low, `irq_pull_en` is 0 and the reference is set to all ones at the clock edge.
- R2: On the first clock edge after reset is released, `irq_pull_en` becomes 1 if any pin is 0, and stays 0 if all pins are 1.
- R3: With no pulse active, if `port_in` differs from the reference in any bit at a clock edge, `irq_pull_en` is 1 after that edge. This holds for both a 0-to-1 and a 1-to-0 change.
- R4: With no pulse active, if `port_in` equals the reference at a clock edge, `irq_pull_en` is 0 after that edge, with no bus access needed.
- R5: An edge with `rd_sample` high loads `port_in` into the reference, so `irq_pull_en` is 0 after that edge.
- R6: At every edge with `wr_commit` high, `irq_pull_en` is 0 after the edge. At the first edge with `wr_commit` low after it was high, the reference loads `port_in`, and `irq_pull_en` is 0 after that edge.
- R7: A pin change present at the same edge as a reference load is compared against the newly loaded value, so it raises no request.
- R8: After a clear by read or by write, a later pin change raises `irq_pull_en` again.
- R9: If `rd_sample` and `wr_commit` are high together, the read load happens at that edge. The request stays masked until the write ends, and the reference reloads when it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_in | input | PORT_W | Synchronized port pin levels |
| rd_sample | input | 1 | One-cycle pulse when the port is sampled for a read |
| wr_commit | input | 1 | High while a written byte is being committed to the port |
| irq_pull_en | output | 1 | 1 pulls the open-drain request line low |

## Verification
Directed sequences exercise several patterns:

- a port held low through reset, to show the power-up request;
- single-bit rises and falls, to separate true mismatches from matches;
- a return to the reference, to show the request withdraws by itself;
- multi-cycle write pulses, with the pins both held and moved, to tell the mask apart from the end-of-write reload;
- a pin change landing on a read sample, to confirm comparison against the new reference;
- overlapping read and write pulses.

A random phase then drives mixed pin bytes and pulse patterns, and compares the output on every cycle against a behavioural model. That model keeps the reference and the previous write level as plain variables.

// File: rtl/pcig_pkg.sv
// Package: shared constants and types for the port change interrupt generator.
// Assumes: nothing beyond IEEE 1800-2017.
package pcig_pkg;
    localparam int unsigned PCIG_DEF_W = 8;

    // Reason a reference reload happens at the current edge.
    typedef enum logic [1:0] {
        UPD_NONE      = 2'd0,
        UPD_READ      = 2'd1,
        UPD_WRITE_END = 2'd2
    } upd_e;
endpackage

// File: rtl/pcig_wr_track.sv
// Module: detects the trailing end of the write-commit pulse.
// Assumes: wr_commit is synchronous to clk; reset is synchronous active-low.
module pcig_wr_track (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_commit,
    output logic wr_end
);
    logic wr_d;

    // Remember the previous write level.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_d <= 1'b0;
        else        wr_d <= wr_commit;
    end

    // Trailing end: high last cycle, low now.
    always_comb wr_end = wr_d & ~wr_commit;
endmodule

// File: rtl/pcig_ref_reg.sv
// Module: reference snapshot of the port, reset to all ones.
// Assumes: load is already qualified by the caller; pins are synchronized.
module pcig_ref_reg #(
    parameter int unsigned W = pcig_pkg::PCIG_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] pins,
    output logic [W-1:0] ref_q,
    output logic [W-1:0] ref_next
);
    localparam logic [W-1:0] REF_RST = {W{1'b1}};

    // Value the reference takes at the coming edge.
    always_comb ref_next = load ? pins : ref_q;

    // Hold the snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= REF_RST;
        else        ref_q <= ref_next;
    end

    assert_ref_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ref_q == $past(pins));
    assert_ref_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ref_q));
endmodule

// File: rtl/pcig_cmp_drive.sv
// Module: per-bit mismatch detect and registered open-drain pull enable.
// Assumes: ref_cmp is the reference value valid after the coming edge.
module pcig_cmp_drive #(
    parameter int unsigned W = pcig_pkg::PCIG_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] ref_cmp,
    input  logic         mask,
    output logic         pull_en
);
    logic [W-1:0] bit_diff;

    // One mismatch flag per port bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb bit_diff[i] = pins[i] ^ ref_cmp[i];
    end

    // Register the request; never drive high, only enable the pull-down.
    always_ff @(posedge clk) begin
        if (!rst_n) pull_en <= 1'b0;
        else        pull_en <= (|bit_diff) & ~mask;
    end

    assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> !pull_en);
endmodule

// File: rtl/port_change_irq.sv
// Module: port change interrupt generator top.
// Compares synchronized pins with a reference refreshed by read samples and
// write-commit ends; drives an open-drain pull enable.
// Assumes: port_in already synchronized; synchronous active-low reset.
module port_change_irq #(
    parameter int unsigned PORT_W = pcig_pkg::PCIG_DEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              rd_sample,
    input  logic              wr_commit,
    output logic              irq_pull_en
);
    import pcig_pkg::*;

    logic              wr_end;
    logic              ref_load;
    upd_e              upd;
    logic [PORT_W-1:0] ref_q;
    logic [PORT_W-1:0] ref_next;

    pcig_wr_track u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .wr_end    (wr_end)
    );

    // Pick the reload reason; read takes precedence when both occur.
    always_comb begin
        if (rd_sample)   upd = UPD_READ;
        else if (wr_end) upd = UPD_WRITE_END;
        else             upd = UPD_NONE;
    end

    // Any reason reloads the reference.
    always_comb ref_load = (upd != UPD_NONE);

    pcig_ref_reg #(.W(PORT_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ref_load),
        .pins     (port_in),
        .ref_q    (ref_q),
        .ref_next (ref_next)
    );

    pcig_cmp_drive #(.W(PORT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (port_in),
        .ref_cmp (ref_next),
        .mask    (wr_commit),
        .pull_en (irq_pull_en)
    );

    assert_detect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_commit && !ref_load && port_in != ref_q) |=> irq_pull_en);
    assert_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_load && port_in == ref_q) |=> !irq_pull_en);
    assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sample |=> !irq_pull_en);
endmodule

// File: tb/tb_port_change_irq.sv
module tb_port_change_irq;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pins = '1;
    logic         rd = 1'b0;
    logic         wr = 1'b0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state.
    logic [W-1:0] m_ref = '1;
    bit           m_irq = 0;
    bit           m_wd = 0;

    always #10 clk = ~clk;

    port_change_irq #(.PORT_W(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_in     (pins),
        .rd_sample   (rd),
        .wr_commit   (wr),
        .irq_pull_en (irq)
    );

    // Model: reload on read or write end, compare against new reference, mask during write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ref = '1; m_irq = 0; m_wd = 0;
        end else begin
            if (rd || (m_wd && !wr)) m_ref = pins;
            m_irq = !wr && (pins != m_ref);
            m_wd  = wr;
        end
    end

    // Per-cycle comparison against the model (R3 general behaviour).
    always @(negedge clk) begin
        checks++;
        if (irq !== m_irq) begin
            errors++;
            $display("FAIL R3 model compare t=%0t actual=%0b expected=%0b", $time, irq, m_irq);
        end
    end

    task automatic chk(input bit exp, input string tag);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    // Set inputs at a negedge, then wait one full cycle so the edge has passed.
    task automatic drive(input logic [W-1:0] p, input bit r, input bit w);
        pins = p; rd = r; wr = w;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        drive(8'hF0, 0, 0);
        drive(8'hF0, 0, 0);
        chk(1'b0, "R1 released during reset");
        rst_n = 1'b1;
        drive(8'hF0, 0, 0);
        chk(1'b1, "R2 low pin after reset");
        drive(8'hF0, 1, 0);
        chk(1'b0, "R5 read clears");
        drive(8'hF0, 0, 0);
        chk(1'b0, "R4 stays clear on match");
        drive(8'hF1, 0, 0);
        chk(1'b1, "R3 rising bit");
        drive(8'hF0, 0, 0);
        chk(1'b0, "R4 return to reference");
        drive(8'hE0, 0, 0);
        chk(1'b1, "R3 falling bit");
        drive(8'hE0, 0, 1);
        chk(1'b0, "R6 masked during write");
        drive(8'hE0, 0, 1);
        chk(1'b0, "R6 masked second write cycle");
        drive(8'hE0, 0, 0);
        chk(1'b0, "R6 write end reload");
        drive(8'hE0, 0, 0);
        chk(1'b0, "R6 reference now E0");
        drive(8'hF0, 0, 1);
        chk(1'b0, "R6 change masked in write");
        drive(8'hF0, 0, 0);
        chk(1'b0, "R6 write end takes F0");
        drive(8'hE0, 0, 0);
        chk(1'b1, "R8 reassert after write clear");
        drive(8'h81, 1, 0);
        chk(1'b0, "R7 change on read edge");
        drive(8'h81, 0, 0);
        chk(1'b0, "R7 reference follows read");
        drive(8'h80, 0, 0);
        chk(1'b1, "R8 reassert after read clear");
        drive(8'h01, 1, 1);
        chk(1'b0, "R9 read and write together");
        drive(8'h01, 0, 0);
        chk(1'b0, "R9 write end reload");
        drive(8'h00, 0, 0);
        chk(1'b1, "R9 later change detected");
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] p;
            p = ($urandom_range(0, 3) == 0) ? W'($urandom) : pins ^ W'(1 << $urandom_range(0, W-1));
            drive(p, ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0));
        end
        drive(pins, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule